// File: doc/BRIEF.md
# Interrupt and Exception Recognition Controller

This block sits next to an instruction sequencer and picks, at each instruction boundary, the single pending request that the core takes next. Requests come in two classes. Edge-type requests (cache purge, system-management entry, soft reset and the non-maskable interrupt) are captured on their rising edge and held until they are taken. Level-type requests (bus error, run/stop, the maskable interrupt and clock stop) are looked at only by their live value at the boundary and are never stored.

Around the selection the block keeps the small amount of state that changes which requests may be taken. After a non-maskable interrupt is granted, further ones are held off until the handler's return retires. The resume flag suppresses one debug fault at the next boundary and then clears itself. The maskable interrupt is gated by the interrupt-enable flag. When a software interrupt goes through a gate that must disable interrupts, the block pulses a request to clear that flag. The grant is a one-cycle one-hot pulse with a matching vector code. Decoding the vector and running the handler belong to the sequencer, which pulses the boundary strobe only where the core can be interrupted.

Top module: `irq_recognizer`

## Requirements
- R1: After a synchronous reset `grant_o`, `vec_o`, `clr_if_o` and `nmi_blocked_o` are 0, and all edge captures and the resume flag are cleared.
- R2: A rising edge on any `edge_req_i` bit creates a pending request that survives any number of cycles without a boundary. An input held high after its request is granted does not create a second request. Bits: 0 cache purge, 1 system management, 2 soft reset, 3 non-maskable.
- R3: `level_req_i` bits (0 bus error, 1 run/stop, 2 maskable, 3 clock stop) count only through their value in the boundary cycle. A level that drops before the boundary is lost, and a level still high is granted again at every boundary.
- R4: When several requests are eligible, exactly one is granted, in this fixed order from highest to lowest, shown with its `grant_o` bit: bus error 0, run/stop 1, cache purge 2, system management 3, soft reset 4, non-maskable 5, debug fault 6, maskable 7, clock stop 8. `vec_o` equals `VEC_BASE` plus the granted bit index (default `VEC_BASE` = 0).
- R5: A grant is a single-cycle, at most one-hot pulse on `grant_o` in the cycle after a cycle with `boundary_i` high. Nothing is granted in any other cycle.
- R6: Edge requests that are still pending are taken at later boundaries one at a time, in the R4 order.
- R7: Granting an edge request clears its capture in the same clock edge. A new rising edge is still captured and granted later.
- R8: A non-maskable grant sets `nmi_blocked_o` in the same cycle. While it is set, no non-maskable grant happens, but a new edge is still captured. An `iret_i` pulse clears the block one cycle later, and the held edge is then granted at the next boundary.
- R9: The maskable request is granted only if `if_flag_i` is 1 in the boundary cycle.
- R10: `clr_if_o` is high for exactly the cycle after each cycle with `swint_gate_i` high.
- R11: An `rf_set_i` pulse sets the resume flag. At the next boundary a `dbg_fault_i` request is suppressed and the flag clears, so the following boundary grants the debug fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| edge_req_i | input | 4 | Edge-type request lines (see R2) |
| level_req_i | input | 4 | Level-type request lines (see R3) |
| boundary_i | input | 1 | Instruction-boundary strobe; recognition point |
| if_flag_i | input | 1 | Current interrupt-enable flag |
| rf_set_i | input | 1 | Sets the resume flag |
| iret_i | input | 1 | Return from the non-maskable handler retired |
| swint_gate_i | input | 1 | Software interrupt through an interrupt-disabling gate |
| dbg_fault_i | input | 1 | Debug fault request |
| grant_o | output | 9 | One-hot grant, bit order as in R4 |
| vec_o | output | VEC_W | Vector code of the grant |
| clr_if_o | output | 1 | Request to clear the interrupt-enable flag |
| nmi_blocked_o | output | 1 | Non-maskable recognition is held off |

## Verification
The selection is driven with single requests of each class, with every edge request at once plus a level request, and with mixed level requests. A single request shows the bit mapping and vector code. The all-at-once pattern shows the priority order and that the captured requests drain one per boundary. The mixed levels separate the live sampling of the level class from the capture of the edge class. Edge requests held across many idle cycles, a level that drops before the boundary, and an input held high across a grant tell capture apart from sampling. The non-maskable block, the enable-flag gate and the one-shot resume flag are each shown with the gate closed and then open.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int N_EDGE = 4;
   localparam int N_LVL  = 4;
   localparam int N_SRC  = 9;

   // edge_req_i bit positions
   localparam int E_PURGE   = 0;
   localparam int E_SYSMGMT = 1;
   localparam int E_SRESET  = 2;
   localparam int E_NONMASK = 3;

   // level_req_i bit positions
   localparam int L_BUSERR   = 0;
   localparam int L_RUNSTOP  = 1;
   localparam int L_MASKABLE = 2;
   localparam int L_CLKSTOP  = 3;

   // grant bit positions, lowest index wins
   localparam int G_BUSERR   = 0;
   localparam int G_RUNSTOP  = 1;
   localparam int G_PURGE    = 2;
   localparam int G_SYSMGMT  = 3;
   localparam int G_SRESET   = 4;
   localparam int G_NONMASK  = 5;
   localparam int G_DEBUG    = 6;
   localparam int G_MASKABLE = 7;
   localparam int G_CLKSTOP  = 8;

   typedef logic [N_SRC-1:0]  src_vec_t;
   typedef logic [N_EDGE-1:0] edge_vec_t;
   typedef logic [N_LVL-1:0]  lvl_vec_t;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] sig_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);
   initial begin : p_param_chk
      assert (N >= 1) else $error("irq_edge_latch: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_src
      logic prev_q;
      logic pend_q;
      logic rise;

      assign rise = sig_i[i] & ~prev_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
         end else begin
            prev_q <= sig_i[i];
            // a fresh edge outranks the clear from a grant
            pend_q <= (pend_q & ~clr_i[i]) | rise;
         end
      end

      assign pend_o[i] = pend_q;
   end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N     = 9,
   parameter int STYLE = 0,
   localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req_i,
   output logic [N-1:0]  gnt_o,
   output logic [IW-1:0] idx_o,
   output logic          any_o
);
   initial begin : p_param_chk
      assert (N >= 2) else $error("irq_prio_pick: N must be at least 2");
      assert (STYLE == 0 || STYLE == 1) else $error("irq_prio_pick: STYLE must be 0 or 1");
   end

   if (STYLE == 0) begin : g_scan
      always_comb begin
         gnt_o = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) gnt_o = N'(1) << i;
         end
      end
   end else begin : g_isolate
      // lowest set bit by two's complement
      assign gnt_o = req_i & (~req_i + N'(1));
   end

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (gnt_o[i]) idx_o = idx_o | IW'(i);
      end
   end

   assign any_o = |req_i;
endmodule

// File: rtl/irq_flag_ctl.sv
module irq_flag_ctl (
   input  logic clk,
   input  logic rst,
   input  logic nmi_take_i,
   input  logic iret_i,
   input  logic rf_set_i,
   input  logic boundary_i,
   input  logic swint_gate_i,
   output logic nmi_blocked_o,
   output logic rf_o,
   output logic clr_if_o
);
   logic blk_q;
   logic rf_q;
   logic clr_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         blk_q <= 1'b0;
         rf_q  <= 1'b0;
         clr_q <= 1'b0;
      end else begin
         if (nmi_take_i)  blk_q <= 1'b1;
         else if (iret_i) blk_q <= 1'b0;

         if (rf_set_i)        rf_q <= 1'b1;
         else if (boundary_i) rf_q <= 1'b0;

         clr_q <= swint_gate_i;
      end
   end

   assign nmi_blocked_o = blk_q;
   assign rf_o          = rf_q;
   assign clr_if_o      = clr_q;
endmodule

// File: rtl/irq_recognizer.sv
module irq_recognizer
   import irq_pkg::*;
#(
   parameter int VEC_W      = 4,
   parameter int VEC_BASE   = 0,
   parameter int PICK_STYLE = 0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [N_EDGE-1:0]   edge_req_i,
   input  logic [N_LVL-1:0]    level_req_i,
   input  logic                boundary_i,
   input  logic                if_flag_i,
   input  logic                rf_set_i,
   input  logic                iret_i,
   input  logic                swint_gate_i,
   input  logic                dbg_fault_i,
   output logic [N_SRC-1:0]    grant_o,
   output logic [VEC_W-1:0]    vec_o,
   output logic                clr_if_o,
   output logic                nmi_blocked_o
);
   localparam int IW      = $clog2(N_SRC);
   localparam int VEC_TOP = VEC_BASE + N_SRC - 1;

   initial begin : p_param_chk
      assert (VEC_BASE >= 0) else $error("irq_recognizer: VEC_BASE must not be negative");
      assert (VEC_TOP < (1 << VEC_W)) else $error("irq_recognizer: VEC_W too narrow for vector codes");
      assert (PICK_STYLE == 0 || PICK_STYLE == 1) else $error("irq_recognizer: bad PICK_STYLE");
   end

   edge_vec_t pend;
   edge_vec_t pend_clr;
   src_vec_t  cand;
   src_vec_t  pick;
   logic [IW-1:0] pick_idx;
   logic      pick_any;
   logic      rf_now;
   logic      take;
   src_vec_t  grant_q;
   logic [VEC_W-1:0] vec_q;

   irq_edge_latch #(.N(N_EDGE)) u_latch (
      .clk    (clk),
      .rst    (rst),
      .sig_i  (edge_req_i),
      .clr_i  (pend_clr),
      .pend_o (pend)
   );

   // eligible requests, in priority order
   always_comb begin
      cand             = '0;
      cand[G_BUSERR]   = level_req_i[L_BUSERR];
      cand[G_RUNSTOP]  = level_req_i[L_RUNSTOP];
      cand[G_PURGE]    = pend[E_PURGE];
      cand[G_SYSMGMT]  = pend[E_SYSMGMT];
      cand[G_SRESET]   = pend[E_SRESET];
      cand[G_NONMASK]  = pend[E_NONMASK] & ~nmi_blocked_o;
      cand[G_DEBUG]    = dbg_fault_i & ~rf_now;
      cand[G_MASKABLE] = level_req_i[L_MASKABLE] & if_flag_i;
      cand[G_CLKSTOP]  = level_req_i[L_CLKSTOP];
   end

   irq_prio_pick #(.N(N_SRC), .STYLE(PICK_STYLE)) u_pick (
      .req_i (cand),
      .gnt_o (pick),
      .idx_o (pick_idx),
      .any_o (pick_any)
   );

   assign take = boundary_i & pick_any;

   always_comb begin
      pend_clr            = '0;
      pend_clr[E_PURGE]   = take & pick[G_PURGE];
      pend_clr[E_SYSMGMT] = take & pick[G_SYSMGMT];
      pend_clr[E_SRESET]  = take & pick[G_SRESET];
      pend_clr[E_NONMASK] = take & pick[G_NONMASK];
   end

   irq_flag_ctl u_flags (
      .clk           (clk),
      .rst           (rst),
      .nmi_take_i    (take & pick[G_NONMASK]),
      .iret_i        (iret_i),
      .rf_set_i      (rf_set_i),
      .boundary_i    (boundary_i),
      .swint_gate_i  (swint_gate_i),
      .nmi_blocked_o (nmi_blocked_o),
      .rf_o          (rf_now),
      .clr_if_o      (clr_if_o)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         grant_q <= '0;
         vec_q   <= '0;
      end else if (take) begin
         grant_q <= pick;
         vec_q   <= VEC_W'(VEC_BASE) + VEC_W'(pick_idx);
      end else begin
         grant_q <= '0;
         vec_q   <= '0;
      end
   end

   assign grant_o = grant_q;
   assign vec_o   = vec_q;
endmodule

module irq_recognizer_chk
   import irq_pkg::*;
#(
   parameter int VEC_W = 4
) (
   input logic              clk,
   input logic              rst,
   input logic [N_EDGE-1:0] edge_req_i,
   input logic [N_LVL-1:0]  level_req_i,
   input logic              boundary_i,
   input logic              if_flag_i,
   input logic              rf_set_i,
   input logic              iret_i,
   input logic              swint_gate_i,
   input logic              dbg_fault_i,
   input logic [N_SRC-1:0]  grant_o,
   input logic [VEC_W-1:0]  vec_o,
   input logic              clr_if_o,
   input logic              nmi_blocked_o
);
   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(grant_o)); // R4
   AST_GRANT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst) (grant_o != '0) |-> $past(boundary_i)); // R5
   AST_NMI_SETS_BLOCK: assert property (@(posedge clk) disable iff (rst) grant_o[G_NONMASK] |-> nmi_blocked_o); // R8
   AST_NO_NMI_WHILE_BLOCKED: assert property (@(posedge clk) disable iff (rst) nmi_blocked_o |=> !grant_o[G_NONMASK]); // R8
   AST_BLOCK_HOLDS: assert property (@(posedge clk) disable iff (rst) (nmi_blocked_o && !iret_i) |=> nmi_blocked_o); // R8
   AST_MASKABLE_GATED: assert property (@(posedge clk) disable iff (rst) !if_flag_i |=> !grant_o[G_MASKABLE]); // R9
   AST_CLR_IF_PULSE: assert property (@(posedge clk) disable iff (rst) swint_gate_i |=> clr_if_o); // R10
   AST_CLR_IF_CAUSE: assert property (@(posedge clk) disable iff (rst) clr_if_o |-> $past(swint_gate_i)); // R10
endmodule

bind irq_recognizer irq_recognizer_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/irq_recognizer_bench.sv
module irq_recognizer_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] edge_req_i = '0;
   logic [3:0] level_req_i = '0;
   logic       boundary_i = 1'b0;
   logic       if_flag_i = 1'b0;
   logic       rf_set_i = 1'b0;
   logic       iret_i = 1'b0;
   logic       swint_gate_i = 1'b0;
   logic       dbg_fault_i = 1'b0;
   logic [8:0] grant_o;
   logic [3:0] vec_o;
   logic       clr_if_o;
   logic       nmi_blocked_o;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_recognizer u_irq_recognizer (
      .clk(clk), .rst(rst), .edge_req_i(edge_req_i), .level_req_i(level_req_i),
      .boundary_i(boundary_i), .if_flag_i(if_flag_i), .rf_set_i(rf_set_i),
      .iret_i(iret_i), .swint_gate_i(swint_gate_i), .dbg_fault_i(dbg_fault_i),
      .grant_o(grant_o), .vec_o(vec_o), .clr_if_o(clr_if_o), .nmi_blocked_o(nmi_blocked_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // one boundary cycle; returns with grant visible
   task automatic bnd();
      boundary_i = 1'b1;
      tick();
      boundary_i = 1'b0;
   endtask

   task automatic grant_is(input string req, input int bitpos);
      chk(req, int'(grant_o), (bitpos < 0) ? 0 : (1 << bitpos));
      chk(req, int'(vec_o), (bitpos < 0) ? 0 : bitpos);
   endtask

   task automatic t_reset();
      chk("R1 grant", int'(grant_o), 0);
      chk("R1 vec", int'(vec_o), 0);
      chk("R1 clr_if", int'(clr_if_o), 0);
      chk("R1 nmi_blocked", int'(nmi_blocked_o), 0);
      bnd();
      grant_is("R1 nothing pending", -1);
   endtask

   task automatic t_edge_capture();
      edge_req_i[0] = 1'b1; tick(); edge_req_i[0] = 1'b0;
      for (int i = 0; i < 5; i++) begin
         tick();
         chk("R5 no grant without boundary", int'(grant_o), 0);
      end
      bnd();
      grant_is("R2 held purge", 2);
      bnd();
      grant_is("R7 capture cleared", -1);
      edge_req_i[2] = 1'b1; tick();
      bnd();
      grant_is("R2 soft reset", 4);
      tick();
      chk("R5 single-cycle grant", int'(grant_o), 0);
      bnd();
      grant_is("R2 held high no re-capture", -1);
      edge_req_i[2] = 1'b0; tick();
   endtask

   task automatic t_regrant_edge();
      edge_req_i[1] = 1'b1; tick(); edge_req_i[1] = 1'b0; tick();
      // new edge arrives in the granting boundary cycle
      edge_req_i[1] = 1'b1;
      bnd();
      edge_req_i[1] = 1'b0;
      grant_is("R7 first grant", 3);
      bnd();
      grant_is("R7 new edge kept", 3);
      bnd();
      grant_is("R7 drained", -1);
   endtask

   task automatic t_level();
      level_req_i[0] = 1'b1; tick(); level_req_i[0] = 1'b0;
      bnd();
      grant_is("R3 dropped level lost", -1);
      level_req_i[1] = 1'b1;
      bnd();
      grant_is("R3 run/stop live", 1);
      bnd();
      grant_is("R3 run/stop again", 1);
      level_req_i[1] = 1'b0;
      bnd();
      grant_is("R3 released", -1);
   endtask

   task automatic t_priority();
      if_flag_i = 1'b1;
      edge_req_i = 4'hF; tick(); edge_req_i = 4'h0;
      level_req_i[3] = 1'b1;
      bnd(); grant_is("R6 purge first", 2);
      bnd(); grant_is("R6 sysmgmt next", 3);
      bnd(); grant_is("R6 soft reset next", 4);
      bnd(); grant_is("R6 nonmask next", 5);
      bnd(); grant_is("R4 clock stop last", 8);
      level_req_i[3] = 1'b0;
      iret_i = 1'b1; tick(); iret_i = 1'b0;
      level_req_i = 4'b0111;
      bnd(); grant_is("R4 bus error over levels", 0);
      level_req_i = 4'b0110;
      bnd(); grant_is("R4 run/stop over maskable", 1);
      level_req_i = 4'b0100;
      dbg_fault_i = 1'b1;
      bnd(); grant_is("R4 debug over maskable", 6);
      dbg_fault_i = 1'b0;
      level_req_i = 4'b1100;
      bnd(); grant_is("R4 maskable over clock stop", 7);
      level_req_i = 4'b0000;
      if_flag_i = 1'b0;
      tick();
   endtask

   task automatic t_nmi();
      chk("R8 block clear before", int'(nmi_blocked_o), 0);
      edge_req_i[3] = 1'b1; tick(); edge_req_i[3] = 1'b0; tick();
      bnd();
      grant_is("R8 nonmask granted", 5);
      chk("R8 block set with grant", int'(nmi_blocked_o), 1);
      edge_req_i[3] = 1'b1; tick(); edge_req_i[3] = 1'b0; tick();
      bnd();
      grant_is("R8 blocked", -1);
      chk("R8 still blocked", int'(nmi_blocked_o), 1);
      iret_i = 1'b1; tick(); iret_i = 1'b0;
      chk("R8 block cleared by iret", int'(nmi_blocked_o), 0);
      bnd();
      grant_is("R8 held edge granted", 5);
      iret_i = 1'b1; tick(); iret_i = 1'b0;
   endtask

   task automatic t_ifmask();
      if_flag_i = 1'b0;
      level_req_i[2] = 1'b1;
      bnd();
      grant_is("R9 masked", -1);
      if_flag_i = 1'b1;
      bnd();
      grant_is("R9 enabled", 7);
      level_req_i[2] = 1'b0;
      if_flag_i = 1'b0;
      tick();
   endtask

   task automatic t_swint();
      chk("R10 idle", int'(clr_if_o), 0);
      swint_gate_i = 1'b1; tick(); swint_gate_i = 1'b0;
      chk("R10 pulse", int'(clr_if_o), 1);
      tick();
      chk("R10 one cycle", int'(clr_if_o), 0);
   endtask

   task automatic t_resume();
      dbg_fault_i = 1'b1;
      rf_set_i = 1'b1; tick(); rf_set_i = 1'b0;
      tick();
      bnd();
      grant_is("R11 suppressed", -1);
      bnd();
      grant_is("R11 flag cleared", 6);
      dbg_fault_i = 1'b0;
      tick();
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         failures++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst = 1'b0;
      tick();
      t_reset();
      t_edge_capture();
      t_regrant_edge();
      t_level();
      t_priority();
      t_nmi();
      t_ifmask();
      t_swint();
      t_resume();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule